// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Controller

This block keeps the status byte of a serial flash device and decides, command by command, whether a write-type operation may start. An upstream decoder drives one strobe for each recognised command. The block answers each strobe with a registered accept or reject pulse and updates the status byte in the same cycle. The status byte holds a busy flag, a write-enable latch, four block-protect bits, an auto-increment mode flag and a lock-down bit.

The lock-down bit and an active-low write-protect pin together guard writes to the status byte. Program and erase commands need the write-enable latch. While an internal operation runs, the status byte stays readable at its port and every command strobe is refused. Array timing lives elsewhere: an external completion pulse ends each operation. For an auto-increment sequence, a level input reports that the last unprotected address was reached.

Top module: `flash_status_ctl`

## Requirements
- R1: On reset the status byte is 0xBC. Bit 0 is busy, bit 1 is the write-enable latch, bits 5:2 are block-protect bits 0..3, bit 6 is the auto-increment mode flag and bit 7 is the lock-down bit. The block-protect bits and the lock-down bit reset to 1, busy, latch and mode flag to 0, and both pulses are low.
- R2: When idle and not in auto-increment mode, a write-enable strobe sets bit 1. A write-disable strobe, accepted whenever not busy, clears bit 1 and bit 6.
- R3: A byte-program, sector, block or chip erase, or auto-increment start strobe with bit 1 at 0 is rejected and leaves the status byte unchanged.
- R4: An accepted byte-program or erase sets bit 0. The next completion pulse clears bits 0 and 1.
- R5: While bit 0 is 1 every command strobe is rejected and the status byte changes only through a completion pulse. A completion pulse while idle has no effect.
- R6: A write-status strobe with bit 1 set is accepted when the write-protect pin is high or bit 7 is 0. Data bit 7 is loaded into bit 7 and data bits 5:2 into bits 5:2. Data bits 6, 1 and 0 are ignored. Bit 1 clears and bit 0 stays 0.
- R7: A write-status strobe with the write-protect pin low and bit 7 at 1 is rejected. Bits 7:1 are unchanged.
- R8: An accepted auto-increment start sets bits 6 and 0. A completion pulse in that mode clears only bit 0. A further start strobe while in the mode and idle is accepted and sets bit 0 again.
- R9: An auto-increment end strobe in the mode while idle is accepted and clears bits 6 and 1. A completion pulse with the limit input high in the mode clears bits 0, 1 and 6.
- R10: In auto-increment mode the write-enable, write-status, byte-program and erase strobes are rejected. An auto-increment end strobe outside the mode is rejected.
- R11: Accept and reject are registered and appear in the cycle after the strobe. Exactly one of them pulses for a cycle with any strobe, and neither pulses otherwise. When several strobes coincide, only the first in this order is handled: write-disable, write-enable, write-status, byte-program, sector, block, chip erase, auto-increment start, auto-increment end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEnableCmd | input | 1 | Write-enable command strobe |
| wrDisableCmd | input | 1 | Write-disable command strobe |
| statusWriteCmd | input | 1 | Write-status command strobe |
| statusWrData | input | 8 | Data byte for write-status |
| byteProgCmd | input | 1 | Byte-program command strobe |
| sectorEraseCmd | input | 1 | Sector erase command strobe |
| blockEraseCmd | input | 1 | Block erase command strobe |
| chipEraseCmd | input | 1 | Chip erase command strobe |
| autoProgStartCmd | input | 1 | Auto-increment program start or next word |
| autoProgEndCmd | input | 1 | Auto-increment program end |
| opDone | input | 1 | Internal operation complete pulse |
| autoLimit | input | 1 | Auto-increment reached last unprotected address |
| wrProtN | input | 1 | Write-protect pin, active low |
| statusByte | output | 8 | Status byte |
| cmdAccept | output | 1 | Command accepted pulse |
| cmdReject | output | 1 | Command rejected pulse |
| busy | output | 1 | Internal operation in progress |

## Verification
The assertions watch every cycle for these rules:
- accept and reject never pulse together;
- a command during busy is refused and the status byte stays frozen;
- the lock-down guard holds;
- busy never rises without an accept;
- a completion pulse clears busy and the latch, including the auto-increment limit exit.

The bench's sequences cover the rest:
- the exact contents loaded by a status write;
- ignored data bits;
- the auto-increment mode walk from start through continuation to end;
- a reset in the middle of a run;
- priority between coinciding strobes.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int STATUS_W = 8;
  localparam int PROT_W   = 4;
  localparam int BUSY_POS = 0;
  localparam int WEL_POS  = 1;
  localparam int PROT_LSB = 2;
  localparam int AUTO_POS = PROT_LSB + PROT_W;
  localparam int LOCK_POS = AUTO_POS + 1;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic setBusy;
    logic clrBusy;
    logic loadProt;
    logic setAuto;
    logic clrAuto;
    logic accept;
    logic reject;
  } ctlStrobes_t;
endpackage

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import fsc_pkg::*;
(
  input  logic        wrEnableCmd,
  input  logic        wrDisableCmd,
  input  logic        statusWriteCmd,
  input  logic        byteProgCmd,
  input  logic        sectorEraseCmd,
  input  logic        blockEraseCmd,
  input  logic        chipEraseCmd,
  input  logic        autoProgStartCmd,
  input  logic        autoProgEndCmd,
  input  logic        opDone,
  input  logic        autoLimit,
  input  logic        wrProtN,
  input  logic        busyQ,
  input  logic        welQ,
  input  logic        autoQ,
  input  logic        lockQ,
  output ctlStrobes_t strobes
);
  logic anyCmd;
  logic progOrErase;

  assign progOrErase = byteProgCmd | sectorEraseCmd | blockEraseCmd | chipEraseCmd;
  assign anyCmd = wrEnableCmd | wrDisableCmd | statusWriteCmd | progOrErase
                | autoProgStartCmd | autoProgEndCmd;

  always_comb begin
    strobes = '0;
    // completion of the running operation
    if (opDone && busyQ) begin
      strobes.clrBusy = 1'b1;
      if (!autoQ || autoLimit) begin
        strobes.clrWel  = 1'b1;
        strobes.clrAuto = 1'b1;
      end
    end
    // command arbitration, fixed priority
    if (anyCmd) begin
      if (busyQ) begin
        strobes.reject = 1'b1;
      end else if (wrDisableCmd) begin
        strobes.accept  = 1'b1;
        strobes.clrWel  = 1'b1;
        strobes.clrAuto = 1'b1;
      end else if (wrEnableCmd) begin
        if (autoQ) strobes.reject = 1'b1;
        else begin
          strobes.accept = 1'b1;
          strobes.setWel = 1'b1;
        end
      end else if (statusWriteCmd) begin
        if (autoQ || !welQ || (!wrProtN && lockQ)) strobes.reject = 1'b1;
        else begin
          strobes.accept   = 1'b1;
          strobes.loadProt = 1'b1;
          strobes.clrWel   = 1'b1;
        end
      end else if (progOrErase) begin
        if (autoQ || !welQ) strobes.reject = 1'b1;
        else begin
          strobes.accept  = 1'b1;
          strobes.setBusy = 1'b1;
        end
      end else if (autoProgStartCmd) begin
        if (!welQ) strobes.reject = 1'b1;
        else begin
          strobes.accept  = 1'b1;
          strobes.setBusy = 1'b1;
          strobes.setAuto = 1'b1;
        end
      end else begin
        if (!autoQ) strobes.reject = 1'b1;
        else begin
          strobes.accept  = 1'b1;
          strobes.clrWel  = 1'b1;
          strobes.clrAuto = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fsc_regs.sv
module fsc_regs
  import fsc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic [STATUS_W-1:0] statusWrData,
  output logic                busyQ,
  output logic                welQ,
  output logic                autoQ,
  output logic                lockQ,
  output logic [STATUS_W-1:0] statusByte,
  output logic                cmdAccept,
  output logic                cmdReject
);
  logic [PROT_W-1:0] protQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      welQ      <= 1'b0;
      autoQ     <= 1'b0;
      lockQ     <= 1'b1;
      protQ     <= '1;
      cmdAccept <= 1'b0;
      cmdReject <= 1'b0;
    end else begin
      cmdAccept <= strobes.accept;
      cmdReject <= strobes.reject;
      if (strobes.setBusy)      busyQ <= 1'b1;
      else if (strobes.clrBusy) busyQ <= 1'b0;
      if (strobes.setWel)       welQ <= 1'b1;
      else if (strobes.clrWel)  welQ <= 1'b0;
      if (strobes.setAuto)      autoQ <= 1'b1;
      else if (strobes.clrAuto) autoQ <= 1'b0;
      if (strobes.loadProt) begin
        lockQ <= statusWrData[LOCK_POS];
        protQ <= statusWrData[PROT_LSB +: PROT_W];
      end
    end
  end

  always_comb begin
    statusByte = '0;
    statusByte[BUSY_POS]            = busyQ;
    statusByte[WEL_POS]             = welQ;
    statusByte[PROT_LSB +: PROT_W]  = protQ;
    statusByte[AUTO_POS]            = autoQ;
    statusByte[LOCK_POS]            = lockQ;
  end
endmodule

// File: rtl/flash_status_ctl.sv
module flash_status_ctl
  import fsc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEnableCmd,
  input  logic                wrDisableCmd,
  input  logic                statusWriteCmd,
  input  logic [STATUS_W-1:0] statusWrData,
  input  logic                byteProgCmd,
  input  logic                sectorEraseCmd,
  input  logic                blockEraseCmd,
  input  logic                chipEraseCmd,
  input  logic                autoProgStartCmd,
  input  logic                autoProgEndCmd,
  input  logic                opDone,
  input  logic                autoLimit,
  input  logic                wrProtN,
  output logic [STATUS_W-1:0] statusByte,
  output logic                cmdAccept,
  output logic                cmdReject,
  output logic                busy
);
  ctlStrobes_t strobes;
  logic busyQ, welQ, autoQ, lockQ;

  fsc_ctrl ctrl_i (
    .wrEnableCmd(wrEnableCmd), .wrDisableCmd(wrDisableCmd),
    .statusWriteCmd(statusWriteCmd), .byteProgCmd(byteProgCmd),
    .sectorEraseCmd(sectorEraseCmd), .blockEraseCmd(blockEraseCmd),
    .chipEraseCmd(chipEraseCmd), .autoProgStartCmd(autoProgStartCmd),
    .autoProgEndCmd(autoProgEndCmd), .opDone(opDone), .autoLimit(autoLimit),
    .wrProtN(wrProtN), .busyQ(busyQ), .welQ(welQ), .autoQ(autoQ),
    .lockQ(lockQ), .strobes(strobes)
  );

  fsc_regs regs_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .statusWrData(statusWrData),
    .busyQ(busyQ), .welQ(welQ), .autoQ(autoQ), .lockQ(lockQ),
    .statusByte(statusByte), .cmdAccept(cmdAccept), .cmdReject(cmdReject)
  );

  assign busy = busyQ;
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEnableCmd,
  input logic       wrDisableCmd,
  input logic       statusWriteCmd,
  input logic       byteProgCmd,
  input logic       sectorEraseCmd,
  input logic       blockEraseCmd,
  input logic       chipEraseCmd,
  input logic       autoProgStartCmd,
  input logic       autoProgEndCmd,
  input logic       opDone,
  input logic       autoLimit,
  input logic       wrProtN,
  input logic [7:0] statusByte,
  input logic       cmdAccept,
  input logic       cmdReject
);
  logic [8:0] cmdVec;
  assign cmdVec = {wrEnableCmd, wrDisableCmd, statusWriteCmd, byteProgCmd,
                   sectorEraseCmd, blockEraseCmd, chipEraseCmd,
                   autoProgStartCmd, autoProgEndCmd};

  p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdAccept && cmdReject));

  p_busy_reject_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[0] && (|cmdVec)) |=> (cmdReject && !cmdAccept));

  p_busy_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[0] && !opDone) |=> $stable(statusByte));

  p_lockdown_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusWriteCmd && !wrProtN && statusByte[7])
      |=> ($stable(statusByte[7]) && $stable(statusByte[5:2])));

  p_need_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (($countones(cmdVec) == 1) && !statusByte[1]
      && (byteProgCmd || sectorEraseCmd || blockEraseCmd || chipEraseCmd || autoProgStartCmd))
      |=> cmdReject);

  p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[0]) |-> cmdAccept);

  p_done_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && statusByte[0] && !statusByte[6]) |=> (!statusByte[0] && !statusByte[1]));

  p_limit_exit_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && statusByte[0] && statusByte[6] && autoLimit)
      |=> (!statusByte[6] && !statusByte[1] && !statusByte[0]));
endmodule

bind flash_status_ctl fsc_checker chk_i (
  .clk(clk), .rstN(rstN), .wrEnableCmd(wrEnableCmd), .wrDisableCmd(wrDisableCmd),
  .statusWriteCmd(statusWriteCmd), .byteProgCmd(byteProgCmd),
  .sectorEraseCmd(sectorEraseCmd), .blockEraseCmd(blockEraseCmd),
  .chipEraseCmd(chipEraseCmd), .autoProgStartCmd(autoProgStartCmd),
  .autoProgEndCmd(autoProgEndCmd), .opDone(opDone), .autoLimit(autoLimit),
  .wrProtN(wrProtN), .statusByte(statusByte), .cmdAccept(cmdAccept),
  .cmdReject(cmdReject)
);

// File: tb/flash_status_ctl_tb_top.sv
module flash_status_ctl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEnableCmd = 0, wrDisableCmd = 0, statusWriteCmd = 0;
  logic [7:0] statusWrData = '0;
  logic byteProgCmd = 0, sectorEraseCmd = 0, blockEraseCmd = 0, chipEraseCmd = 0;
  logic autoProgStartCmd = 0, autoProgEndCmd = 0, opDone = 0, autoLimit = 0;
  logic wrProtN = 1'b1;
  logic [7:0] statusByte;
  logic cmdAccept, cmdReject, busy;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_status_ctl dut_i (.*);

  // {cmd[4], data[8], wrProtN, opDone, autoLimit, expStatus[8], expAcc, expRej, req[4]}
  // cmd: 0 none 1 wrEnable 2 wrDisable 3 statusWrite 4 byteProg 5 sector
  //      6 block 7 chip 8 autoStart 9 autoEnd
  localparam int NV = 41;
  localparam logic [28:0] VEC [NV] = '{
    {4'd4, 8'h00, 3'b100, 8'hBC, 2'b01, 4'd3},  // R3 no latch
    {4'd1, 8'h00, 3'b100, 8'hBE, 2'b10, 4'd2},  // R2
    {4'd3, 8'h00, 3'b000, 8'hBE, 2'b01, 4'd7},  // R7 locked
    {4'd3, 8'h00, 3'b100, 8'h00, 2'b10, 4'd6},  // R6 pin high
    {4'd1, 8'h00, 3'b100, 8'h02, 2'b10, 4'd2},
    {4'd3, 8'h43, 3'b000, 8'h00, 2'b10, 4'd6},  // R6 ignored bits, unlocked
    {4'd1, 8'h00, 3'b100, 8'h02, 2'b10, 4'd2},
    {4'd5, 8'h00, 3'b100, 8'h03, 2'b10, 4'd4},  // R4
    {4'd1, 8'h00, 3'b100, 8'h03, 2'b01, 4'd5},  // R5 busy
    {4'd0, 8'h00, 3'b110, 8'h00, 2'b00, 4'd4},  // R4 done
    {4'd0, 8'h00, 3'b110, 8'h00, 2'b00, 4'd5},  // R5 idle done
    {4'd1, 8'h00, 3'b100, 8'h02, 2'b10, 4'd2},
    {4'd8, 8'h00, 3'b100, 8'h43, 2'b10, 4'd8},  // R8
    {4'd0, 8'h00, 3'b110, 8'h42, 2'b00, 4'd8},
    {4'd4, 8'h00, 3'b100, 8'h42, 2'b01, 4'd10}, // R10
    {4'd8, 8'h00, 3'b100, 8'h43, 2'b10, 4'd8},
    {4'd9, 8'h00, 3'b100, 8'h43, 2'b01, 4'd5},
    {4'd0, 8'h00, 3'b110, 8'h42, 2'b00, 4'd8},
    {4'd9, 8'h00, 3'b100, 8'h00, 2'b10, 4'd9},  // R9 end
    {4'd9, 8'h00, 3'b100, 8'h00, 2'b01, 4'd10},
    {4'd1, 8'h00, 3'b100, 8'h02, 2'b10, 4'd2},
    {4'd8, 8'h00, 3'b100, 8'h43, 2'b10, 4'd8},
    {4'd0, 8'h00, 3'b111, 8'h00, 2'b00, 4'd9},  // R9 limit
    {4'd1, 8'h00, 3'b100, 8'h02, 2'b10, 4'd2},
    {4'd7, 8'h00, 3'b100, 8'h03, 2'b10, 4'd4},
    {4'd0, 8'h00, 3'b110, 8'h00, 2'b00, 4'd4},
    {4'd1, 8'h00, 3'b100, 8'h02, 2'b10, 4'd2},
    {4'd2, 8'h00, 3'b100, 8'h00, 2'b10, 4'd2},
    {4'd1, 8'h00, 3'b100, 8'h02, 2'b10, 4'd2},
    {4'd3, 8'hBC, 3'b000, 8'hBC, 2'b10, 4'd6},
    {4'd1, 8'h00, 3'b100, 8'hBE, 2'b10, 4'd2},
    {4'd3, 8'h00, 3'b000, 8'hBE, 2'b01, 4'd7},
    {4'd3, 8'h00, 3'b100, 8'h00, 2'b10, 4'd6},
    {4'd1, 8'h00, 3'b100, 8'h02, 2'b10, 4'd2},
    {4'd6, 8'h00, 3'b100, 8'h03, 2'b10, 4'd4},
    {4'd0, 8'h00, 3'b110, 8'h00, 2'b00, 4'd4},
    {4'd1, 8'h00, 3'b100, 8'h02, 2'b10, 4'd2},
    {4'd8, 8'h00, 3'b100, 8'h43, 2'b10, 4'd8},
    {4'd0, 8'h00, 3'b110, 8'h42, 2'b00, 4'd8},
    {4'd1, 8'h00, 3'b100, 8'h42, 2'b01, 4'd10},
    {4'd2, 8'h00, 3'b100, 8'h00, 2'b10, 4'd2}
  };

  task automatic clearIn();
    wrEnableCmd = 0; wrDisableCmd = 0; statusWriteCmd = 0; byteProgCmd = 0;
    sectorEraseCmd = 0; blockEraseCmd = 0; chipEraseCmd = 0;
    autoProgStartCmd = 0; autoProgEndCmd = 0; opDone = 0; autoLimit = 0;
    statusWrData = '0; wrProtN = 1'b1;
  endtask

  task automatic driveCmd(input logic [3:0] c);
    case (c)
      4'd1: wrEnableCmd = 1;
      4'd2: wrDisableCmd = 1;
      4'd3: statusWriteCmd = 1;
      4'd4: byteProgCmd = 1;
      4'd5: sectorEraseCmd = 1;
      4'd6: blockEraseCmd = 1;
      4'd7: chipEraseCmd = 1;
      4'd8: autoProgStartCmd = 1;
      4'd9: autoProgEndCmd = 1;
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [7:0] expS,
                       input logic expA, input logic expR);
    checks++;
    if (statusByte !== expS || cmdAccept !== expA || cmdReject !== expR) begin
      fails++;
      $display("FAIL %s: status=%h acc=%b rej=%b expected status=%h acc=%b rej=%b",
               tag, statusByte, cmdAccept, cmdReject, expS, expA, expR);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 8'hBC, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 8'hBC, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      clearIn();
      driveCmd(v[28:25]);
      statusWrData = v[24:17];
      wrProtN = v[16];
      opDone = v[15];
      autoLimit = v[14];
      @(negedge clk);
      check($sformatf("R%0d vector %0d", v[3:0], i), v[13:6], v[5], v[4]);
    end
    clearIn();

    // R11 priority: write-disable beats write-enable, state 0x00
    wrEnableCmd = 1; wrDisableCmd = 1;
    @(negedge clk);
    clearIn();
    check("R11 priority", 8'h00, 1'b1, 1'b0);
    @(negedge clk);
    check("R11 no strobe no pulse", 8'h00, 1'b0, 1'b0);

    // R1 mid-run reset restores protected state
    wrEnableCmd = 1;
    @(negedge clk);
    clearIn();
    check("R2 set before reset", 8'h02, 1'b1, 1'b0);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", 8'hBC, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule